// File: doc/BRIEF.md
# Grouped Priority Interrupt Controller

This block gathers a bank of interrupt request lines, arranged as numbered groups of equal width, and turns them into a single request for a processor core. Every group has one programmable priority register. The register sets one of four levels for the group and a handler offset that the core adds to its vector base. The core supplies a global mask bit and one mask bit per level from its status register. The block then reports the winning request as a valid flag, a level code and the offset of the handler.

A dedicated non-maskable request bypasses all masking and reports a level code of its own. A small register port lets software program the priority registers. The same port also reads back the raw lines of any group, so a handler can see which sources inside its group are active. The outputs are registered once.

Top module: `grp_irq_ctrl`

## Requirements
- R1: A group is pending when at least one of its request lines is high; group g owns lines `irq_lines[g*LINES_PER_GRP +: LINES_PER_GRP]`.
- R2: Writing address g (0 to NUM_GRP-1) loads group g's priority register: level from data bits [31:30], offset from bits [13:0]. A read of that address returns those fields in the same positions and zero in bits [29:14]. The registers reset to level 0 and offset 0.
- R3: While `mask_global` is high, no group request is reported.
- R4: While `mask_level[L]` is high, groups whose level is L are not reported; other levels are unaffected.
- R5: Among unmasked pending groups, the one with the highest level wins, and its level and offset are reported.
- R6: When several unmasked pending groups share the highest level, the group with the highest number wins.
- R7: A high `nmi_req` gives `out_valid`=1 and `out_level`=4 whatever the masks and group requests are. `out_offset` carries no meaning in that case.
- R8: When no request survives masking and `nmi_req` is low, `out_valid`, `out_level` and `out_offset` are all 0.
- R9: Outputs are registered. They reflect the inputs and register contents sampled at the previous rising clock edge, and they are 0 while reset is active.
- R10: Reading address NUM_GRP+g returns group g's raw request lines in bits [LINES_PER_GRP-1:0] and zero above. The read data is combinational from the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_lines | input | NUM_GRP*LINES_PER_GRP | Request lines, grouped |
| nmi_req | input | 1 | Non-maskable request |
| mask_global | input | 1 | Global mask from core status |
| mask_level | input | 4 | Per-level masks, bit L masks level L |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| out_valid | output | 1 | A request is being presented |
| out_level | output | 3 | Level 0 to 3, or 4 for non-maskable |
| out_offset | output | 14 | Handler offset of the winning group |

## Verification
The bench builds the block with its defaults: 8 groups of 8 lines and a 4-bit address. With these values, two groups sit on each level, and the level programming of the bench puts ties both at the lowest and at the highest level. That lets the tie-break to the higher group number be seen at both ends of the scan. A 64-bit stimulus word also reaches the edge lines of the first and last groups, so a slicing error at a group boundary shows up as a wrong winner.

// File: rtl/gic_pkg.sv
package gic_pkg;
  localparam int LVL_W     = 2;
  localparam int NUM_LVL   = 1 << LVL_W;
  localparam int OFS_W     = 14;
  localparam int REG_W     = 32;
  localparam int OUT_LVL_W = 3;
  localparam int LVL_HI    = 31;
  localparam int LVL_LO    = 30;
  localparam logic [OUT_LVL_W-1:0] NMI_CODE = 3'd4;

  typedef struct packed {
    logic [LVL_W-1:0] lvl;
    logic [OFS_W-1:0] ofs;
  } prio_t;
endpackage

// File: rtl/gic_rst_sync.sv
module gic_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_core_n = sync_q[1];
endmodule

// File: rtl/gic_prio_regs.sv
module gic_prio_regs
  import gic_pkg::*;
#(
  parameter int NUM_GRP = 8,
  parameter int ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [LVL_W-1:0]   wr_lvl,
  input  logic [OFS_W-1:0]   wr_ofs,
  output prio_t              prio_o [NUM_GRP]
);
  prio_t prio_q [NUM_GRP];
  prio_t prio_d [NUM_GRP];

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_reg
    logic hit;
    assign hit = wr_en && (addr == ADDR_W'(g));

    always_comb begin
      prio_d[g] = prio_q[g];
      if (hit) begin
        prio_d[g].lvl = wr_lvl;
        prio_d[g].ofs = wr_ofs;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prio_q[g] <= '0;
      end else if (hit) begin
        prio_q[g] <= prio_d[g];
      end
    end

    assign prio_o[g] = prio_q[g];
  end
endmodule

// File: rtl/gic_grp_gate.sv
module gic_grp_gate
  import gic_pkg::*;
#(
  parameter int NUM_GRP       = 8,
  parameter int LINES_PER_GRP = 8
) (
  input  logic [NUM_GRP*LINES_PER_GRP-1:0] irq_lines,
  input  prio_t                            prio [NUM_GRP],
  input  logic                             mask_global,
  input  logic [NUM_LVL-1:0]               mask_level,
  output logic [NUM_GRP-1:0]               grp_live
);
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_gate
    logic pend;
    logic lvl_blk;
    assign pend    = |irq_lines[g*LINES_PER_GRP +: LINES_PER_GRP];
    assign lvl_blk = mask_level[prio[g].lvl];
    assign grp_live[g] = pend && !mask_global && !lvl_blk;
  end
endmodule

// File: rtl/gic_arbiter.sv
module gic_arbiter
  import gic_pkg::*;
#(
  parameter int NUM_GRP = 8
) (
  input  logic [NUM_GRP-1:0]    grp_live,
  input  prio_t                 prio [NUM_GRP],
  input  logic                  nmi_req,
  output logic                  win_valid,
  output logic [OUT_LVL_W-1:0]  win_level,
  output logic [OFS_W-1:0]      win_offset
);
  logic             found;
  logic [LVL_W-1:0] best_lvl;
  logic [OFS_W-1:0] best_ofs;

  // Ascending scan with >= lets a later (higher numbered) group take a tie.
  always_comb begin
    found    = 1'b0;
    best_lvl = '0;
    best_ofs = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (grp_live[g] && (!found || prio[g].lvl >= best_lvl)) begin
        found    = 1'b1;
        best_lvl = prio[g].lvl;
        best_ofs = prio[g].ofs;
      end
    end
  end

  always_comb begin
    if (nmi_req) begin
      win_valid  = 1'b1;
      win_level  = NMI_CODE;
      win_offset = '0;
    end else begin
      win_valid  = found;
      win_level  = {1'b0, best_lvl};
      win_offset = best_ofs;
    end
  end
endmodule

// File: rtl/grp_irq_ctrl.sv
module grp_irq_ctrl
  import gic_pkg::*;
#(
  parameter int NUM_GRP       = 8,
  parameter int LINES_PER_GRP = 8,
  parameter int ADDR_W        = $clog2(2 * NUM_GRP)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_GRP*LINES_PER_GRP-1:0] irq_lines,
  input  logic                             nmi_req,
  input  logic                             mask_global,
  input  logic [3:0]                       mask_level,
  input  logic                             reg_wr,
  input  logic [ADDR_W-1:0]                reg_addr,
  input  logic [31:0]                      reg_wdata,
  output logic [31:0]                      reg_rdata,
  output logic                             out_valid,
  output logic [2:0]                       out_level,
  output logic [13:0]                      out_offset
);
  localparam int PAD_W = REG_W - LVL_W - OFS_W;

  logic                 rst_core_n;
  prio_t                prio [NUM_GRP];
  logic [NUM_GRP-1:0]   grp_live;
  logic                 win_valid;
  logic [OUT_LVL_W-1:0] win_level;
  logic [OFS_W-1:0]     win_offset;
  logic                 unused_wdata_bits;

  assign unused_wdata_bits = ^reg_wdata[LVL_LO-1:OFS_W];

  gic_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  gic_prio_regs #(.NUM_GRP(NUM_GRP), .ADDR_W(ADDR_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .wr_en  (reg_wr),
    .addr   (reg_addr),
    .wr_lvl (reg_wdata[LVL_HI:LVL_LO]),
    .wr_ofs (reg_wdata[OFS_W-1:0]),
    .prio_o (prio)
  );

  gic_grp_gate #(.NUM_GRP(NUM_GRP), .LINES_PER_GRP(LINES_PER_GRP)) u_gate (
    .irq_lines   (irq_lines),
    .prio        (prio),
    .mask_global (mask_global),
    .mask_level  (mask_level),
    .grp_live    (grp_live)
  );

  gic_arbiter #(.NUM_GRP(NUM_GRP)) u_arb (
    .grp_live   (grp_live),
    .prio       (prio),
    .nmi_req    (nmi_req),
    .win_valid  (win_valid),
    .win_level  (win_level),
    .win_offset (win_offset)
  );

  // Read mux: priority registers first, raw group lines above them.
  always_comb begin
    reg_rdata = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (reg_addr == ADDR_W'(g)) begin
        reg_rdata = {prio[g].lvl, {PAD_W{1'b0}}, prio[g].ofs};
      end
      if (reg_addr == ADDR_W'(NUM_GRP + g)) begin
        reg_rdata = REG_W'(irq_lines[g*LINES_PER_GRP +: LINES_PER_GRP]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      out_valid  <= 1'b0;
      out_level  <= '0;
      out_offset <= '0;
    end else begin
      out_valid  <= win_valid;
      out_level  <= win_level;
      out_offset <= win_offset;
    end
  end
endmodule

// File: rtl/grp_irq_ctrl_chk.sv
module grp_irq_ctrl_chk #(
  parameter int NUM_BITS = 64
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_BITS-1:0] irq_lines,
  input logic                nmi_req,
  input logic                mask_global,
  input logic [3:0]          mask_level,
  input logic                out_valid,
  input logic [2:0]          out_level,
  input logic [13:0]         out_offset
);
  logic       armed;
  logic [3:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      mask_q <= '0;
    end else begin
      armed  <= 1'b1;
      mask_q <= mask_level;
    end
  end

  // R7
  nmi_override_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(nmi_req) |-> (out_valid && out_level == 3'd4));

  // R3
  global_mask_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    ($past(mask_global) && !$past(nmi_req)) |-> !out_valid);

  // R4
  level_mask_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (out_valid && out_level != 3'd4) |-> !mask_q[out_level[1:0]]);

  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (!$past(|irq_lines) && !$past(nmi_req)) |-> (!out_valid && out_level == 3'd0 && out_offset == 14'd0));

  // R9
  level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_level <= 3'd4);
endmodule

bind grp_irq_ctrl grp_irq_ctrl_chk #(.NUM_BITS(NUM_GRP*LINES_PER_GRP)) u_chk (
  .clk         (clk),
  .rst_n       (rst_core_n),
  .irq_lines   (irq_lines),
  .nmi_req     (nmi_req),
  .mask_global (mask_global),
  .mask_level  (mask_level),
  .out_valid   (out_valid),
  .out_level   (out_level),
  .out_offset  (out_offset)
);

// File: tb/grp_irq_ctrl_tb.sv
`timescale 1ns/1ps
module grp_irq_ctrl_tb;
  logic        clk;
  logic        rst_n;
  logic [63:0] irq_lines;
  logic        nmi_req;
  logic        mask_global;
  logic [3:0]  mask_level;
  logic        reg_wr;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        out_valid;
  logic [2:0]  out_level;
  logic [13:0] out_offset;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  grp_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .nmi_req(nmi_req),
    .mask_global(mask_global), .mask_level(mask_level), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .out_valid(out_valid), .out_level(out_level), .out_offset(out_offset)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Vector: {irq[63:0], nmi, gmask, lmask[3:0], exp_valid, exp_level[2:0], exp_ofs[13:0]}
  // Group levels programmed: g0:0 g1:1 g2:2 g3:3 g4:1 g5:3 g6:0 g7:2, offset 0x100+16*g.
  localparam int NV = 13;
  localparam logic [87:0] VEC [NV] = '{
    {64'h0000_0000_0000_0000, 1'b0, 1'b0, 4'h0, 1'b0, 3'd0, 14'h000},
    {64'h0000_0000_0000_0008, 1'b0, 1'b0, 4'h0, 1'b1, 3'd0, 14'h100},
    {64'h0000_0000_0080_0100, 1'b0, 1'b0, 4'h0, 1'b1, 3'd2, 14'h120},
    {64'h0000_0200_0100_0000, 1'b0, 1'b0, 4'h0, 1'b1, 3'd3, 14'h150},
    {64'h0000_0220_0100_0000, 1'b0, 1'b0, 4'h8, 1'b1, 3'd1, 14'h140},
    {64'h0000_0220_0100_0000, 1'b0, 1'b1, 4'h0, 1'b0, 3'd0, 14'h000},
    {64'h0000_0000_0000_0000, 1'b1, 1'b1, 4'hF, 1'b1, 3'd4, 14'h000},
    {64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 4'h0, 1'b1, 3'd4, 14'h000},
    {64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0, 4'h0, 1'b1, 3'd3, 14'h150},
    {64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0, 4'hC, 1'b1, 3'd1, 14'h140},
    {64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0, 4'hF, 1'b0, 3'd0, 14'h000},
    {64'h0080_0000_0000_0001, 1'b0, 1'b0, 4'h0, 1'b1, 3'd0, 14'h160},
    {64'h0100_0000_0000_0000, 1'b0, 1'b0, 4'h1, 1'b1, 3'd2, 14'h170}
  };

  function automatic string vec_tag(int i);
    case (i)
      0: return "R8";  1: return "R1";  2: return "R5";  3: return "R6";
      4: return "R4";  5: return "R3";  6: return "R7";  7: return "R7";
      8: return "R6";  9: return "R4";  10: return "R4"; 11: return "R6";
      default: return "R1";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [3:0] a, logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 reset valid", {31'd0, out_valid}, 32'd0);
    check("R9 reset level/offset", {15'd0, out_level, out_offset}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [31:0] prio_word(int g);
    logic [1:0] lv;
    case (g % 8)
      0: lv = 2'd0; 1: lv = 2'd1; 2: lv = 2'd2; 3: lv = 2'd3;
      4: lv = 2'd1; 5: lv = 2'd3; 6: lv = 2'd0; default: lv = 2'd2;
    endcase
    return {lv, 16'h0, 14'(14'h100 + 14'(g * 16))};
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; irq_lines = '1; nmi_req = 1'b1; mask_global = 1'b0;
    mask_level = 4'h0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    // R9: outputs held at zero in reset even with requests present
    check("R9 in-reset outputs", {28'd0, out_valid, out_level}, 32'd0);
    irq_lines = '0; nmi_req = 1'b0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2: priority register reset value
    rd_chk("R2 reset value", 4'd3, 32'h0);

    for (int g = 0; g < 8; g++) wr_reg(4'(g), prio_word(g));
    // R2: read back, reserved bits written as ones read as zero
    rd_chk("R2 readback g2", 4'd2, 32'h8000_0120);
    wr_reg(4'd5, 32'hFFFF_C150);
    rd_chk("R2 reserved bits", 4'd5, 32'hC000_0150);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      irq_lines   = VEC[i][87:24];
      nmi_req     = VEC[i][23];
      mask_global = VEC[i][22];
      mask_level  = VEC[i][21:18];
      @(negedge clk);
      if (VEC[i][16:14] == 3'd4)
        check(vec_tag(i), {14'd0, out_valid, out_level, 14'd0},
              {14'd0, VEC[i][17], VEC[i][16:14], 14'd0});
      else
        check(vec_tag(i), {14'd0, out_valid, out_level, out_offset},
              {14'd0, VEC[i][17:0]});
    end

    // R10: raw request readback for first and last group
    @(negedge clk);
    irq_lines = 64'hA500_0000_0000_003C; nmi_req = 1'b0; mask_global = 1'b0; mask_level = 4'h0;
    rd_chk("R10 raw g0", 4'd8, 32'h0000_003C);
    rd_chk("R10 raw g7", 4'd15, 32'h0000_00A5);

    // R9: input change not visible before the next edge
    @(negedge clk);
    irq_lines = 64'h0000_0000_0000_0000;
    @(negedge clk);
    irq_lines = 64'h0000_0000_0000_0100;
    #1;
    check("R9 no early change", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    check("R9 one-cycle latency", {29'd0, out_level}, 32'd1);

    // R2/R9: level change takes effect one cycle after the write edge
    reg_addr = 4'd1; reg_wdata = 32'hC000_0111; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    check("R9 old level after write", {18'd0, out_level, 11'd0}, {18'd0, 3'd1, 11'd0});
    @(negedge clk);
    check("R2 new level/offset", {15'd0, out_level, out_offset}, {15'd0, 3'd3, 14'h111});

    // R4: masking a level other than the winner's leaves it untouched
    mask_level = 4'h7;
    @(negedge clk);
    check("R4 other levels masked", {15'd0, out_level, out_offset}, {15'd0, 3'd3, 14'h111});

    // R2: second reset clears priority registers
    do_reset();
    rd_chk("R2 cleared by reset", 4'd1, 32'h0);

    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule